// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Check

This block holds recently used virtual-to-physical page mappings for a single access port. A request carries a virtual address, an access kind (read or write) and the privilege of the requester (kernel or user). The tag of every entry is compared against the virtual page number in parallel. The permission check runs in the same cycle as the compare. One clock edge later the block presents a single outcome: a hit with the physical address, a miss, or a protection fault. The page offset passes through unchanged.

A miss tells the surrounding logic to walk the page tables. The walker then writes the mapping back through the refill port. A refill whose page is already held overwrites that entry in place. A refill of a new page takes the lowest-numbered empty entry, and when the table is full it evicts an entry chosen first-in-first-out (the default) or by a free-running pseudo-random sequence (a parameter option). Entries carry no process tag, so software flushes the whole table on a context switch.

Top module: `tlb_assoc`

## Requirements
- R1: While reset is asserted and after it is released, every entry is invalid and all response outputs are 0 until a request is made.
- R2: A request sampled at a clock edge produces rsp_valid_o on the following cycle, with exactly one of rsp_hit_o, rsp_miss_o, rsp_fault_o set. Without a request all four are 0 and rsp_paddr_o is 0.
- R3: On a hit, rsp_paddr_o[31:12] is the stored physical page number of the matching entry and rsp_paddr_o[11:0] equals the request's address bits [11:0].
- R4: A request whose address bits [31:12] match no valid entry reports a miss with rsp_paddr_o equal to 0.
- R5: On a tag match, a read needs the entry's read bit and a write needs its write bit. A user-mode request (req_user_i=1) also needs the entry's user bit, while kernel mode ignores it. A failed check reports a fault with rsp_paddr_o equal to 0.
- R6: A write that matches an entry whose dirty bit is 0 reports a fault, even when the write bit is 1.
- R7: A refill whose page number is already held updates that entry's physical page and permission bits and takes no new entry.
- R8: A refill of a new page uses the lowest-numbered invalid entry. When no entry is invalid it replaces the entry allocated longest ago (FIFO mode). Every new allocation advances the replacement pointer.
- R9: An asserted flush_i invalidates every entry and returns the replacement pointer to entry 0.
- R10: When flush_i and fill_valid_i are both asserted in one cycle, the flush wins and the refill is dropped.
- R11: A lookup sees the table as it was before any refill or flush applied in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 32 | Virtual address of the lookup |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| fill_valid_i | input | 1 | Refill write from the walker |
| fill_vpn_i | input | 20 | Virtual page number to install |
| fill_ppn_i | input | 20 | Physical page number to install |
| fill_read_i | input | 1 | Read permission of the new entry |
| fill_write_i | input | 1 | Write permission of the new entry |
| fill_dirty_i | input | 1 | Dirty bit of the new entry |
| fill_user_i | input | 1 | User-accessible bit of the new entry |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Translation succeeded |
| rsp_miss_o | output | 1 | No valid entry matched |
| rsp_fault_o | output | 1 | Entry matched but access not permitted |
| rsp_paddr_o | output | 32 | Physical address on a hit, else 0 |

## Verification
Lookups of held pages are made with varied offsets, read and write kinds and both privilege levels, so that translation, offset passthrough and each permission bit are each isolated. A lookup made in the same cycle as a refill or a flush separates the old table from the new one. Filling the table past capacity and then probing the oldest, the second-oldest and the newest pages shows which entry the FIFO pointer evicts. After a flush, the same overflow shows whether the pointer was returned to entry 0. A re-fill of a page that is already held, followed by a full table, shows whether the update took an extra entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic {
        REPL_FIFO   = 1'b0,
        REPL_RANDOM = 1'b1
    } repl_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic dirty;
        logic user;
    } perm_t;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N     = 32,
    parameter int KEY_W = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]        key,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);

    logic [N-1:0] match;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = valid[i] && (keys[i] == key);
    end

    assign any = |match;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  perm_t perm,
    input  logic  is_write,
    input  logic  is_user,
    output logic  fault
);

    logic kind_bad;
    logic mode_bad;

    always_comb begin
        if (is_write) kind_bad = !perm.wr || !perm.dirty;
        else          kind_bad = !perm.rd;
        mode_bad = is_user && !perm.user;
        fault    = kind_bad || mode_bad;
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid,
    input  logic [IDX_W-1:0] repl_idx,
    output logic [IDX_W-1:0] victim
);

    logic             have_free;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
        victim = have_free ? free_idx : repl_idx;
    end

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
    import tlb_pkg::*;
#(
    parameter int    VA_W    = 32,
    parameter int    OFF_W   = 12,
    parameter int    PPN_W   = 20,
    parameter int    ENTRIES = 32,
    parameter repl_e REPL    = REPL_FIFO,
    localparam int   VPN_W   = VA_W - OFF_W,
    localparam int   PA_W    = PPN_W + OFF_W,
    localparam int   IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             req_valid_i,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic             req_write_i,
    input  logic             req_user_i,
    input  logic             fill_valid_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PPN_W-1:0] fill_ppn_i,
    input  logic             fill_read_i,
    input  logic             fill_write_i,
    input  logic             fill_dirty_i,
    input  logic             fill_user_i,
    output logic             rsp_valid_o,
    output logic             rsp_hit_o,
    output logic             rsp_miss_o,
    output logic             rsp_fault_o,
    output logic [PA_W-1:0]  rsp_paddr_o
);

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        perm_t [ENTRIES-1:0]           perm;
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [IDX_W-1:0]              ptr;
        logic [15:0]                   lfsr;
        logic                          rsp_v;
        logic                          rsp_h;
        logic                          rsp_m;
        logic                          rsp_f;
        logic [PA_W-1:0]               rsp_pa;
    } state_t;

    state_t state_d, state_q;

    logic [VPN_W-1:0] req_vpn;
    logic             lk_any, fl_any, lk_fault;
    logic [IDX_W-1:0] lk_idx, fl_idx, vic_idx, repl_idx, wr_idx;

    assign req_vpn = req_vaddr_i[VA_W-1:OFF_W];

    tlb_cam #(.N(ENTRIES), .KEY_W(VPN_W)) u_cam_lookup (
        .valid (state_q.vld),
        .keys  (state_q.tag),
        .key   (req_vpn),
        .any   (lk_any),
        .idx   (lk_idx)
    );

    tlb_cam #(.N(ENTRIES), .KEY_W(VPN_W)) u_cam_fill (
        .valid (state_q.vld),
        .keys  (state_q.tag),
        .key   (fill_vpn_i),
        .any   (fl_any),
        .idx   (fl_idx)
    );

    tlb_perm u_perm (
        .perm     (state_q.perm[lk_idx]),
        .is_write (req_write_i),
        .is_user  (req_user_i),
        .fault    (lk_fault)
    );

    if (REPL == REPL_RANDOM) begin : g_rand
        assign repl_idx = state_q.lfsr[IDX_W-1:0];
    end else begin : g_fifo
        assign repl_idx = state_q.ptr;
    end

    tlb_victim #(.N(ENTRIES)) u_victim (
        .valid    (state_q.vld),
        .repl_idx (repl_idx),
        .victim   (vic_idx)
    );

    assign wr_idx = fl_any ? fl_idx : vic_idx;

    always_comb begin
        state_d = state_q;
        state_d.lfsr = {state_q.lfsr[14:0],
                        state_q.lfsr[15] ^ state_q.lfsr[13] ^
                        state_q.lfsr[12] ^ state_q.lfsr[10]};

        state_d.rsp_v  = req_valid_i;
        state_d.rsp_h  = 1'b0;
        state_d.rsp_m  = 1'b0;
        state_d.rsp_f  = 1'b0;
        state_d.rsp_pa = '0;
        if (req_valid_i) begin
            if (!lk_any) begin
                state_d.rsp_m = 1'b1;
            end else if (lk_fault) begin
                state_d.rsp_f = 1'b1;
            end else begin
                state_d.rsp_h  = 1'b1;
                state_d.rsp_pa = {state_q.ppn[lk_idx], req_vaddr_i[OFF_W-1:0]};
            end
        end

        if (flush_i) begin
            state_d.vld = '0;
            state_d.ptr = '0;
        end else if (fill_valid_i) begin
            if (!fl_any) state_d.ptr = state_q.ptr + 1'b1;
            state_d.vld[wr_idx]        = 1'b1;
            state_d.tag[wr_idx]        = fill_vpn_i;
            state_d.ppn[wr_idx]        = fill_ppn_i;
            state_d.perm[wr_idx].rd    = fill_read_i;
            state_d.perm[wr_idx].wr    = fill_write_i;
            state_d.perm[wr_idx].dirty = fill_dirty_i;
            state_d.perm[wr_idx].user  = fill_user_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.lfsr <= LFSR_SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid_o = state_q.rsp_v;
    assign rsp_hit_o   = state_q.rsp_h;
    assign rsp_miss_o  = state_q.rsp_m;
    assign rsp_fault_o = state_q.rsp_f;
    assign rsp_paddr_o = state_q.rsp_pa;

endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush_i,
    input logic            req_valid_i,
    input logic [VA_W-1:0] req_vaddr_i,
    input logic            rsp_valid_o,
    input logic            rsp_hit_o,
    input logic            rsp_miss_o,
    input logic            rsp_fault_o,
    input logic [PA_W-1:0] rsp_paddr_o
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o);

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> ($countones({rsp_hit_o, rsp_miss_o, rsp_fault_o}) == 1));

    // R2
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_o |-> (!rsp_hit_o && !rsp_miss_o && !rsp_fault_o && rsp_paddr_o == '0));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit_o |-> (rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0])));

    // R4
    no_addr_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss_o || rsp_fault_o) |-> (rsp_paddr_o == '0));

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i ##1 req_valid_i |=> rsp_miss_o);

endmodule

bind tlb_assoc tlb_assoc_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .req_valid_i (req_valid_i),
    .req_vaddr_i (req_vaddr_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_hit_o   (rsp_hit_o),
    .rsp_miss_o  (rsp_miss_o),
    .rsp_fault_o (rsp_fault_o),
    .rsp_paddr_o (rsp_paddr_o)
);

// File: tb/tlb_assoc_bench.sv
module tlb_assoc_bench;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush_i;
    logic        req_valid_i;
    logic [31:0] req_vaddr_i;
    logic        req_write_i;
    logic        req_user_i;
    logic        fill_valid_i;
    logic [19:0] fill_vpn_i;
    logic [19:0] fill_ppn_i;
    logic        fill_read_i, fill_write_i, fill_dirty_i, fill_user_i;
    logic        rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o;
    logic [31:0] rsp_paddr_o;

    always #10 clk = ~clk;

    tlb_assoc u_tlb_assoc (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .req_valid_i  (req_valid_i),
        .req_vaddr_i  (req_vaddr_i),
        .req_write_i  (req_write_i),
        .req_user_i   (req_user_i),
        .fill_valid_i (fill_valid_i),
        .fill_vpn_i   (fill_vpn_i),
        .fill_ppn_i   (fill_ppn_i),
        .fill_read_i  (fill_read_i),
        .fill_write_i (fill_write_i),
        .fill_dirty_i (fill_dirty_i),
        .fill_user_i  (fill_user_i),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_hit_o    (rsp_hit_o),
        .rsp_miss_o   (rsp_miss_o),
        .rsp_fault_o  (rsp_fault_o),
        .rsp_paddr_o  (rsp_paddr_o)
    );

    // Behavioural reference: a list of held mappings in allocation slots
    logic        m_v   [N];
    logic [19:0] m_tag [N];
    logic [19:0] m_ppn [N];
    logic        m_r [N], m_w [N], m_d [N], m_u [N];
    int          m_ptr;

    int    errors = 0;
    int    checks = 0;
    bit    done   = 0;

    logic        e_valid, e_hit, e_miss, e_fault;
    logic [31:0] e_paddr;
    string       e_req;

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        m_ptr = 0;
    endtask

    task automatic tick();
        int idx;
        int slot;
        logic bad;
        // expected response, from the table before this cycle's update (R11)
        idx = -1;
        e_valid = req_valid_i; e_hit = 0; e_miss = 0; e_fault = 0; e_paddr = 0;
        e_req = "R2";
        if (req_valid_i) begin
            for (int i = 0; i < N; i++)
                if (idx < 0 && m_v[i] && m_tag[i] == req_vaddr_i[31:12]) idx = i;
            if (idx < 0) begin
                e_miss = 1; e_req = "R4";
            end else begin
                bad = req_write_i ? !m_w[idx] : !m_r[idx];
                if (req_user_i && !m_u[idx]) bad = 1;
                if (bad) begin
                    e_fault = 1; e_req = "R5";
                end else if (req_write_i && !m_d[idx]) begin
                    e_fault = 1; e_req = "R6";
                end else begin
                    e_hit = 1; e_req = "R3";
                    e_paddr = {m_ppn[idx], req_vaddr_i[11:0]};
                end
            end
        end
        // table update: flush wins (R10), else refill (R7, R8)
        if (flush_i) begin
            model_clear();
        end else if (fill_valid_i) begin
            slot = -1;
            for (int i = 0; i < N; i++)
                if (slot < 0 && m_v[i] && m_tag[i] == fill_vpn_i) slot = i;
            if (slot < 0) begin
                for (int i = 0; i < N; i++)
                    if (slot < 0 && !m_v[i]) slot = i;
                if (slot < 0) slot = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_v[slot] = 1; m_tag[slot] = fill_vpn_i; m_ppn[slot] = fill_ppn_i;
            m_r[slot] = fill_read_i; m_w[slot] = fill_write_i;
            m_d[slot] = fill_dirty_i; m_u[slot] = fill_user_i;
        end
        @(posedge clk);
        @(negedge clk);
        check_bit(e_req, "rsp_valid", rsp_valid_o, e_valid);
        check_bit(e_req, "rsp_hit",   rsp_hit_o,   e_hit);
        check_bit(e_req, "rsp_miss",  rsp_miss_o,  e_miss);
        check_bit(e_req, "rsp_fault", rsp_fault_o, e_fault);
        checks++;
        if (rsp_paddr_o !== e_paddr) begin
            errors++;
            $display("FAIL %s rsp_paddr actual=%h expected=%h", e_req, rsp_paddr_o, e_paddr);
        end
    endtask

    task automatic set_req(input logic [31:0] va, input logic wr, input logic usr);
        req_valid_i = 1; req_vaddr_i = va; req_write_i = wr; req_user_i = usr;
    endtask

    task automatic set_fill(input logic [19:0] vpn, input logic [19:0] ppn,
                            input logic r, input logic w, input logic d, input logic u);
        fill_valid_i = 1; fill_vpn_i = vpn; fill_ppn_i = ppn;
        fill_read_i = r; fill_write_i = w; fill_dirty_i = d; fill_user_i = u;
    endtask

    task automatic clear_in();
        req_valid_i = 0; fill_valid_i = 0; flush_i = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic wr, input logic usr);
        set_req(va, wr, usr); tick(); clear_in();
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic r, input logic w, input logic d, input logic u);
        set_fill(vpn, ppn, r, w, d, u); tick(); clear_in();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; clear_in();
        req_vaddr_i = 0; req_write_i = 0; req_user_i = 0;
        fill_vpn_i = 0; fill_ppn_i = 0;
        fill_read_i = 0; fill_write_i = 0; fill_dirty_i = 0; fill_user_i = 0;
        model_clear();
        // R1: outputs idle under reset, even with a request pending
        set_req(32'h0001_0000, 0, 0);
        repeat (3) @(negedge clk);
        check_bit("R1", "rsp_valid in reset", rsp_valid_o, 1'b0);
        check_bit("R1", "rsp_hit in reset",   rsp_hit_o,   1'b0);
        clear_in();
        @(negedge clk);
        rst_n = 1;
        tick();
        // R1: empty table after reset
        look(32'h0001_0123, 0, 0);

        // R3: translation with offset passthrough, several offsets and kinds
        fill(20'h00010, 20'h0ABCD, 1, 1, 1, 1);
        look(32'h0001_0123, 0, 1);
        look(32'h0001_0FFF, 1, 1);
        look(32'h0001_0000, 0, 0);

        // R11: lookup in the cycle of the refill sees the old table
        set_fill(20'h00020, 20'h12345, 1, 1, 1, 1);
        set_req(32'h0002_0456, 0, 0);
        tick(); clear_in();
        look(32'h0002_0456, 0, 0);

        // R5: read-only kernel page
        fill(20'h00030, 20'h00777, 1, 0, 1, 0);
        look(32'h0003_0010, 0, 1);
        look(32'h0003_0010, 0, 0);
        look(32'h0003_0010, 1, 0);
        // R5: write-only page refuses reads
        fill(20'h00050, 20'h00555, 0, 1, 1, 1);
        look(32'h0005_0abc, 0, 1);
        look(32'h0005_0abc, 1, 1);

        // R6: clean writable page faults on write
        fill(20'h00040, 20'h00888, 1, 1, 0, 1);
        look(32'h0004_0020, 1, 1);
        look(32'h0004_0020, 0, 1);
        // R7: refill sets dirty in place
        fill(20'h00040, 20'h00999, 1, 1, 1, 1);
        look(32'h0004_0020, 1, 1);

        // R7 R8: fill to capacity; the in-place update took no extra entry
        for (int i = 0; i < N - 5; i++) fill(20'h00100 + 20'(i), 20'h40000 + 20'(i), 1, 1, 1, 1);
        look(32'h0001_0004, 0, 0);
        look(32'h0004_0008, 0, 0);
        for (int i = 0; i < N - 5; i++) look({20'h00100 + 20'(i), 12'h3c0}, 0, 0);
        // R8: oldest (first allocated) evicted, then the next oldest
        fill(20'h00200, 20'h0F00D, 1, 1, 1, 1);
        look(32'h0001_0004, 0, 0);
        look(32'h0002_0004, 0, 0);
        look(32'h0020_0004, 0, 0);
        fill(20'h00201, 20'h0F00E, 1, 1, 1, 1);
        look(32'h0002_0004, 0, 0);
        look(32'h0003_0004, 0, 0);

        // R10 R11: flush and refill together, with a lookup of an old page
        flush_i = 1;
        set_fill(20'h00300, 20'h0BEEF, 1, 1, 1, 1);
        set_req(32'h0003_0044, 0, 0);
        tick(); clear_in();
        look(32'h0030_0044, 0, 0);
        // R9: everything gone
        look(32'h0003_0044, 0, 0);
        look(32'h0020_0044, 0, 0);

        // R9: pointer back at entry 0 after the flush
        for (int i = 0; i < N; i++) fill(20'h00500 + 20'(i), 20'h50000 + 20'(i), 1, 1, 1, 1);
        fill(20'h00600, 20'h60000, 1, 1, 1, 1);
        look(32'h0050_0000, 0, 0);
        look(32'h0050_1000, 0, 0);
        look(32'h0050_2000, 0, 0);
        look(32'h0060_0000, 0, 1);
        tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule